// File: doc/BRIEF.md
# Word-Read RX Frame FIFO

This block is the receive store of a CAN FD controller. A frame producer hands it complete frames as a stream of 32-bit words. The first word of each frame is a header. Its low five bits hold a word count equal to the frame's total word count minus one. The next word holds the identifier, and the payload words follow. The header alone decides whether the frame fits. A frame that fits is written into a circular word RAM. It becomes visible to the reader only when its last word has been written. A frame that does not fit is swallowed in full, and the overrun flag and event are raised.

Software drains the store one word per read strobe. The block reloads its count of words left in the current frame from every header it reads. It keeps a count of complete frames still stored and reports pointers, free space, the empty and full flags and a running count of received frames.

The store input is a valid/ready stream. A word moves on a cycle where both `in_valid` and `in_ready` are high. `in_ready` is low only in a cycle where `cmd_release` is high, so a producer may hold a word for any number of cycles and the block never stalls it for space: a frame without room is consumed and discarded. The read side, the commands and the status outputs are plain signals.

Top module: `rx_frame_fifo`

## Requirements
- R1: Bits [4:0] of a frame's first word give N, and the frame is N+1 words long. The words of a stored frame are read back in the order they were written.
- R2: When a header arrives and the stored words plus N+1 exceed the capacity, none of the frame's N+1 words is stored. `overrun` is then set and `ev_overrun` pulses for one cycle in the cycle after the header is taken.
- R3: When the last word of an accepted frame is taken, the stored word count rises by N+1. In the same step `frame_cnt` and `rx_frames` each rise by one, and `ev_rx` pulses in the following cycle. The stored count never exceeds the capacity.
- R4: A read strobe with stored words present puts the word at the read pointer on `rd_data` in the next cycle. It advances `rd_ptr` by one modulo the capacity and lowers the stored count by one.
- R5: `frame_cnt` drops by one when the (N+1)th word of a frame, counted from its header, is read. `rx_empty` is high exactly when `frame_cnt` is zero.
- R6: A read strobe while no word is stored gives zero on `rd_data` in the next cycle and changes no pointer or count.
- R7: `wr_ptr` equals (`rd_ptr` + stored words) modulo the capacity. `free_words` is the capacity minus the stored words, and `size_words` is the capacity, all in 32-bit words.
- R8: `rx_full` is high exactly when the stored words equal the capacity.
- R9: `cmd_clr_overrun` clears `overrun`. An overrun detected in the same cycle leaves the flag set.
- R10: `cmd_release` zeroes the read pointer, stored words, frame count and remaining-word count. A frame half-written at that moment is discarded up to its last word, and a read strobe in the same cycle returns zero.
- R11: `cmd_clr_rx_count` zeroes `rx_frames`. A frame committed in the same cycle leaves the counter at one.
- R12: `in_ready` is high in every cycle where `cmd_release` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Store stream word valid |
| in_data | input | 32 | Store stream word |
| in_ready | output | 1 | Store stream ready |
| rd_en | input | 1 | Read strobe for one word |
| rd_data | output | 32 | Word read, valid the cycle after the strobe |
| cmd_clr_overrun | input | 1 | Clear the overrun flag |
| cmd_release | input | 1 | Empty the store and reset its pointers |
| cmd_clr_rx_count | input | 1 | Zero the received-frame counter |
| rx_empty | output | 1 | No complete frame stored |
| rx_full | output | 1 | Stored words equal capacity |
| overrun | output | 1 | Sticky overrun flag |
| ev_rx | output | 1 | One-cycle pulse per accepted frame |
| ev_overrun | output | 1 | One-cycle pulse per dropped frame |
| rx_frames | output | CNT_W | Received-frame counter |
| frame_cnt | output | AW+1 | Complete frames stored |
| rd_ptr | output | AW | Read pointer in words |
| wr_ptr | output | AW | Write pointer in words |
| free_words | output | AW+1 | Free space in words |
| size_words | output | AW+1 | Capacity in words |

## Verification
The bench builds the block with a 32-word capacity instead of 256. Four eight-word frames then fill it exactly, and a further header meets the overrun path within a few dozen cycles. Pointer wrap-around is reached several times during the mixed read-and-store phase, and the largest legal frame (32 words) equals the full capacity. A behavioural queue model is compared on every clock. It covers commits and reads landing in the same cycle, a release cut into a half-stored frame, and clear commands that collide with the events they clear.

// File: rtl/rxfifo_pkg.sv
`timescale 1ns/1ps
package rxfifo_pkg;
  localparam int WORD_W   = 32;
  localparam int WCNT_W   = 5;
  localparam int WCNT_LSB = 0;
  localparam int FRW_W    = WCNT_W + 1;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_FILL = 2'd1,
    ST_SKIP = 2'd2
  } store_state_e;

  function automatic logic [FRW_W-1:0] hdr_words(input logic [WCNT_W-1:0] wcnt);
    return {1'b0, wcnt} + FRW_W'(1);
  endfunction
endpackage

// File: rtl/rxf_ram.sv
`timescale 1ns/1ps
module rxf_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [AW-1:0]                 waddr,
  input  logic [rxfifo_pkg::WORD_W-1:0] wdata,
  input  logic [AW-1:0]                 raddr,
  output logic [rxfifo_pkg::WORD_W-1:0] rdata
);
  logic [rxfifo_pkg::WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxf_store.sv
`timescale 1ns/1ps
module rxf_store #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [rxfifo_pkg::WORD_W-1:0] in_data,
  output logic                          in_ready,
  input  logic                          release_i,
  input  logic [AW:0]                   stored_words,
  input  logic [AW-1:0]                 head_ptr,
  output logic                          ram_we,
  output logic [AW-1:0]                 ram_waddr,
  output logic [rxfifo_pkg::WORD_W-1:0] ram_wdata,
  output logic                          commit,
  output logic [AW:0]                   commit_words,
  output logic                          drop
);
  import rxfifo_pkg::*;
  localparam int OW = AW + 1;

  store_state_e     st_q, st_d;
  logic [FRW_W-1:0] left_q, left_d;
  logic [FRW_W-1:0] frw_q, frw_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [FRW_W-1:0] hw;
  logic             acc, fits;

  assign hw        = hdr_words(in_data[WCNT_LSB +: WCNT_W]);
  assign in_ready  = !release_i;
  assign acc       = in_valid && in_ready;
  assign fits      = (int'(stored_words) + int'(hw)) <= DEPTH;
  assign ram_wdata = in_data;
  assign commit_words = (st_q == ST_HDR) ? OW'(hw) : OW'(frw_q);

  always_comb begin
    st_d      = st_q;
    left_d    = left_q;
    frw_d     = frw_q;
    addr_d    = addr_q;
    ram_we    = 1'b0;
    ram_waddr = addr_q;
    commit    = 1'b0;
    drop      = 1'b0;
    unique case (st_q)
      ST_HDR: begin
        if (acc) begin
          if (fits) begin
            ram_we    = 1'b1;
            ram_waddr = head_ptr;
            if (hw == FRW_W'(1)) begin
              commit = 1'b1;
            end else begin
              st_d   = ST_FILL;
              left_d = hw - FRW_W'(1);
              frw_d  = hw;
              addr_d = head_ptr + AW'(1);
            end
          end else begin
            drop = 1'b1;
            if (hw != FRW_W'(1)) begin
              st_d   = ST_SKIP;
              left_d = hw - FRW_W'(1);
            end
          end
        end
      end
      ST_FILL: begin
        if (release_i) begin
          st_d = ST_SKIP;
        end else if (acc) begin
          ram_we = 1'b1;
          addr_d = addr_q + AW'(1);
          left_d = left_q - FRW_W'(1);
          if (left_q == FRW_W'(1)) begin
            commit = 1'b1;
            st_d   = ST_HDR;
          end
        end
      end
      ST_SKIP: begin
        if (acc) begin
          left_d = left_q - FRW_W'(1);
          if (left_q == FRW_W'(1)) st_d = ST_HDR;
        end
      end
      default: st_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HDR;
      left_q <= '0;
      frw_q  <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
      frw_q  <= frw_d;
      addr_q <= addr_d;
    end
  end

  // R3: a committed frame always fits into what is stored at that moment
  p_commit_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (int'(stored_words) + int'(commit_words)) <= DEPTH);
  // R1: while mid-frame there is always at least one word still owed
  p_left_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_HDR) |-> (left_q != '0));
  // R2: a dropped header never reaches the RAM
  p_drop_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> !ram_we && !commit);
endmodule

// File: rtl/rxf_drain.sv
`timescale 1ns/1ps
module rxf_drain #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  logic                          release_i,
  input  logic [AW:0]                   stored_words,
  input  logic [rxfifo_pkg::WORD_W-1:0] ram_rdata,
  output logic [AW-1:0]                 rd_ptr,
  output logic [rxfifo_pkg::WORD_W-1:0] rd_data,
  output logic                          rd_ok,
  output logic                          frame_done
);
  import rxfifo_pkg::*;

  logic [FRW_W-1:0] rem_q, cur_rem, rem_after;

  assign rd_ok      = rd_en && (stored_words != '0) && !release_i;
  assign cur_rem    = (rem_q == '0) ? hdr_words(ram_rdata[WCNT_LSB +: WCNT_W]) : rem_q;
  assign rem_after  = cur_rem - FRW_W'(1);
  assign frame_done = rd_ok && (rem_after == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      rem_q   <= '0;
      rd_data <= '0;
    end else if (release_i) begin
      rd_ptr  <= '0;
      rem_q   <= '0;
      rd_data <= '0;
    end else begin
      rd_data <= rd_ok ? ram_rdata : '0;
      if (rd_ok) begin
        rd_ptr <= rd_ptr + AW'(1);
        rem_q  <= rem_after;
      end
    end
  end

  // R6: reading an empty store yields zero and leaves the pointer alone
  p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && stored_words == '0 && !release_i) |=> (rd_data == '0) && $stable(rd_ptr));
  // R4: each accepted read moves the pointer by exactly one word
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> rd_ptr == AW'($past(rd_ptr) + AW'(1)));
  // R10: release returns the read side to its origin
  p_release_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> (rd_ptr == '0) && (rd_data == '0));
endmodule

// File: rtl/rxf_occupancy.sv
`timescale 1ns/1ps
module rxf_occupancy #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [AW:0]      commit_words,
  input  logic             drop,
  input  logic             rd_ok,
  input  logic             frame_done,
  input  logic             release_i,
  input  logic             clr_ovr,
  input  logic             clr_rxcnt,
  output logic [AW:0]      stored_words,
  output logic [AW:0]      frame_cnt,
  output logic             overrun,
  output logic [CNT_W-1:0] rx_count,
  output logic             ev_rx,
  output logic             ev_ovr
);
  logic [AW:0] add_w, sub_w, add_f, sub_f;

  assign add_w = commit ? commit_words : '0;
  assign sub_w = rd_ok ? (AW+1)'(1) : '0;
  assign add_f = commit ? (AW+1)'(1) : '0;
  assign sub_f = frame_done ? (AW+1)'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_words <= '0;
      frame_cnt    <= '0;
      overrun      <= 1'b0;
      rx_count     <= '0;
      ev_rx        <= 1'b0;
      ev_ovr       <= 1'b0;
    end else begin
      if (release_i) begin
        stored_words <= '0;
        frame_cnt    <= '0;
      end else begin
        stored_words <= stored_words + add_w - sub_w;
        frame_cnt    <= frame_cnt + add_f - sub_f;
      end
      if (drop)         overrun <= 1'b1;
      else if (clr_ovr) overrun <= 1'b0;
      if (clr_rxcnt) rx_count <= commit ? CNT_W'(1) : '0;
      else if (commit) rx_count <= rx_count + CNT_W'(1);
      ev_rx  <= commit;
      ev_ovr <= drop;
    end
  end

  // R3: stored words stay within capacity
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stored_words) <= DEPTH);
  // R5: no frame stored implies no word stored
  p_frames_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_cnt == '0) |-> (stored_words == '0));
  // R2: a drop leaves the sticky flag and the event set
  p_drop_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun && ev_ovr);
  // R10: release empties the counts
  p_release_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> (stored_words == '0) && (frame_cnt == '0));
endmodule

// File: rtl/rx_frame_fifo.sv
`timescale 1ns/1ps
module rx_frame_fifo #(
  parameter int DEPTH = 256,
  parameter int CNT_W = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  input  logic             rd_en,
  output logic [31:0]      rd_data,
  input  logic             cmd_clr_overrun,
  input  logic             cmd_release,
  input  logic             cmd_clr_rx_count,
  output logic             rx_empty,
  output logic             rx_full,
  output logic             overrun,
  output logic             ev_rx,
  output logic             ev_overrun,
  output logic [CNT_W-1:0] rx_frames,
  output logic [AW:0]      frame_cnt,
  output logic [AW-1:0]    rd_ptr,
  output logic [AW-1:0]    wr_ptr,
  output logic [AW:0]      free_words,
  output logic [AW:0]      size_words
);
  logic [AW:0]   stored_words, commit_words;
  logic          ram_we, commit, drop, rd_ok, frame_done;
  logic [AW-1:0] ram_waddr;
  logic [31:0]   ram_wdata, ram_rdata;

  assign wr_ptr     = rd_ptr + stored_words[AW-1:0];
  assign free_words = (AW+1)'(DEPTH) - stored_words;
  assign size_words = (AW+1)'(DEPTH);
  assign rx_full    = (stored_words == (AW+1)'(DEPTH));
  assign rx_empty   = (frame_cnt == '0);

  rxf_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(rd_ptr), .rdata(ram_rdata)
  );

  rxf_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .release_i(cmd_release), .stored_words(stored_words),
    .head_ptr(wr_ptr), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .commit(commit), .commit_words(commit_words),
    .drop(drop)
  );

  rxf_drain #(.DEPTH(DEPTH), .AW(AW)) u_drain (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .release_i(cmd_release),
    .stored_words(stored_words), .ram_rdata(ram_rdata), .rd_ptr(rd_ptr),
    .rd_data(rd_data), .rd_ok(rd_ok), .frame_done(frame_done)
  );

  rxf_occupancy #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_words(commit_words),
    .drop(drop), .rd_ok(rd_ok), .frame_done(frame_done),
    .release_i(cmd_release), .clr_ovr(cmd_clr_overrun),
    .clr_rxcnt(cmd_clr_rx_count), .stored_words(stored_words),
    .frame_cnt(frame_cnt), .overrun(overrun), .rx_count(rx_frames),
    .ev_rx(ev_rx), .ev_ovr(ev_overrun)
  );

  // R8: full and free space agree
  p_full_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> (free_words == '0) && !rx_empty);
endmodule

// File: tb/rx_frame_fifo_bench.sv
`timescale 1ns/1ps
module rx_frame_fifo_bench;
  localparam int DEPTH = 32;
  localparam int CNT_W = 16;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, rd_en = 1'b0;
  logic [31:0] in_data = '0;
  logic c_ovr = 1'b0, c_rel = 1'b0, c_rxc = 1'b0;
  logic in_ready, rx_empty, rx_full, overrun, ev_rx, ev_overrun;
  logic [31:0] rd_data;
  logic [CNT_W-1:0] rx_frames;
  logic [AW:0] frame_cnt, free_words, size_words;
  logic [AW-1:0] rd_ptr, wr_ptr;

  always #2.5 clk = ~clk;

  rx_frame_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx_frame_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rd_en(rd_en), .rd_data(rd_data),
    .cmd_clr_overrun(c_ovr), .cmd_release(c_rel), .cmd_clr_rx_count(c_rxc),
    .rx_empty(rx_empty), .rx_full(rx_full), .overrun(overrun), .ev_rx(ev_rx),
    .ev_overrun(ev_overrun), .rx_frames(rx_frames), .frame_cnt(frame_cnt),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .free_words(free_words),
    .size_words(size_words)
  );

  int checks = 0, errors = 0;

  // reference model
  logic [31:0] q[$];
  logic [31:0] stage[$];
  int m_mode = 0, m_left = 0, m_rem = 0, m_rdp = 0, m_frames = 0;
  int m_rxc = 0;
  bit m_ovr = 0, m_evrx = 0, m_evov = 0;
  logic [31:0] m_rdata = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update();
    int stored_pre, w;
    bit rd_ok, acc, do_commit;
    logic [31:0] word;
    stored_pre = q.size();
    rd_ok = rd_en && stored_pre != 0 && !c_rel;
    acc = in_valid && !c_rel;
    do_commit = 0;
    m_evov = 0;
    m_rdata = rd_ok ? q[0] : 32'h0;
    if (c_rel) begin
      if (m_mode == 1) m_mode = 2;
      stage.delete();
    end else if (acc) begin
      if (m_mode == 0) begin
        w = int'(in_data[4:0]) + 1;
        if (stored_pre + w <= DEPTH) begin
          stage.delete(); stage.push_back(in_data);
          if (w == 1) do_commit = 1; else begin m_mode = 1; m_left = w - 1; end
        end else begin
          m_evov = 1;
          if (w > 1) begin m_mode = 2; m_left = w - 1; end
        end
      end else if (m_mode == 1) begin
        stage.push_back(in_data); m_left--;
        if (m_left == 0) begin do_commit = 1; m_mode = 0; end
      end else begin
        m_left--;
        if (m_left == 0) m_mode = 0;
      end
    end
    if (rd_ok) begin
      word = q.pop_front();
      if (m_rem == 0) m_rem = int'(word[4:0]) + 1;
      m_rem--;
      if (m_rem == 0) m_frames--;
      m_rdp = (m_rdp + 1) % DEPTH;
    end
    if (do_commit) begin
      foreach (stage[i]) q.push_back(stage[i]);
      stage.delete();
      m_frames++;
    end
    m_evrx = do_commit;
    if (c_rxc) m_rxc = do_commit ? 1 : 0;
    else if (do_commit) m_rxc++;
    if (c_rel) begin q.delete(); m_rdp = 0; m_rem = 0; m_frames = 0; end
    if (m_evov) m_ovr = 1; else if (c_ovr) m_ovr = 0;
  endtask

  task automatic compare();
    int st;
    st = q.size();
    chk(rd_data === m_rdata, "R4/R6 rd_data", rd_data, m_rdata);
    chk(int'(rd_ptr) == m_rdp, "R4 rd_ptr", rd_ptr, m_rdp);
    chk(int'(free_words) == DEPTH - st, "R7 free_words", free_words, DEPTH - st);
    chk(int'(wr_ptr) == (m_rdp + st) % DEPTH, "R7 wr_ptr", wr_ptr, (m_rdp + st) % DEPTH);
    chk(int'(size_words) == DEPTH, "R7 size_words", size_words, DEPTH);
    chk(int'(frame_cnt) == m_frames, "R5 frame_cnt", frame_cnt, m_frames);
    chk(rx_empty == (m_frames == 0), "R5 rx_empty", rx_empty, m_frames == 0);
    chk(rx_full == (st == DEPTH), "R8 rx_full", rx_full, st == DEPTH);
    chk(overrun == m_ovr, "R2/R9 overrun", overrun, m_ovr);
    chk(int'(rx_frames) == m_rxc, "R3/R11 rx_frames", rx_frames, m_rxc);
    chk(ev_rx == m_evrx, "R3 ev_rx", ev_rx, m_evrx);
    chk(ev_overrun == m_evov, "R2 ev_overrun", ev_overrun, m_evov);
  endtask

  task automatic step();
    #1;
    chk(in_ready == !c_rel, "R12 in_ready", in_ready, !c_rel);
    @(posedge clk);
    #1;
    model_update();
    compare();
  endtask

  task automatic push(input int wcnt, input int tag, input bit rd);
    for (int i = 0; i <= wcnt; i++) begin
      in_valid = 1'b1;
      in_data = (i == 0) ? {tag[26:0], wcnt[4:0]} : {tag[15:0], i[15:0]};
      rd_en = rd;
      step();
    end
    in_valid = 1'b0; rd_en = 1'b0;
  endtask

  task automatic reads(input int n);
    for (int i = 0; i < n; i++) begin rd_en = 1'b1; step(); end
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();                                   // reset state
    chk(rx_empty && !overrun && rx_frames == 0, "R5 reset state", rx_empty, 1);
    reads(2);                                 // R6 empty reads
    push(3, 16'hA1, 0);                       // R1 four-word frame
    reads(4);                                 // R4 R5 drain it
    push(0, 16'hB2, 0);                       // R1 single-word frame
    reads(1);
    for (int f = 0; f < 4; f++) push(7, 16'hC0 + f, 0); // R8 exact fill, wraps
    chk(rx_full == 1'b1, "R8 full after exact fill", rx_full, 1);
    push(0, 16'hD0, 0);                       // R2 drop single word
    push(2, 16'hD1, 0);                       // R2 drop three words
    chk(overrun == 1'b1, "R2 overrun set", overrun, 1);
    c_ovr = 1'b1; step(); c_ovr = 1'b0;       // R9 clear
    c_ovr = 1'b1; in_valid = 1'b1; in_data = 32'h0000_0000; step(); // R9 clash
    c_ovr = 1'b0; in_valid = 1'b0;
    chk(overrun == 1'b1, "R9 set wins over clear", overrun, 1);
    c_ovr = 1'b1; step(); c_ovr = 1'b0;
    reads(10);
    push(1, 16'hE0, 1);                       // R3 store while reading
    c_rxc = 1'b1; step(); c_rxc = 1'b0;       // R11 clear
    in_valid = 1'b1; in_data = 32'h0000_0101; step();
    c_rxc = 1'b1; in_data = 32'h0000_7777; step(); // R11 clash with commit
    c_rxc = 1'b0; in_valid = 1'b0;
    chk(rx_frames == 1, "R11 commit after clear", rx_frames, 1);
    in_valid = 1'b1; in_data = 32'h0000_0F04; step(); // R10 header of 5-word frame
    in_data = 32'h0000_0F01; step();
    in_valid = 1'b0; c_rel = 1'b1; rd_en = 1'b1; step(); // R10 release mid-store
    c_rel = 1'b0; rd_en = 1'b0;
    chk(frame_cnt == 0 && rd_ptr == 0 && rd_data == 0, "R10 release", frame_cnt, 0);
    for (int i = 0; i < 3; i++) begin in_valid = 1'b1; in_data = 32'h0000_0F10; step(); end
    in_valid = 1'b0;
    chk(free_words == DEPTH, "R10 tail discarded", free_words, DEPTH);
    push(2, 16'hF0, 0);
    reads(3);
    lfsr = 16'hACE1;
    for (int it = 0; it < 400; it++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[1:0] == 2'b00) push(int'(lfsr[6:2]) % 12, it, lfsr[7]);
      else if (lfsr[1:0] == 2'b01) reads(int'(lfsr[5:2]));
      else if (lfsr[9:2] == 8'h13) begin c_rel = 1'b1; step(); c_rel = 1'b0; end
      else begin
        c_ovr = lfsr[8]; c_rxc = (lfsr[12:10] == 3'b000);
        rd_en = lfsr[9]; step();
        c_ovr = 1'b0; c_rxc = 1'b0; rd_en = 1'b0;
      end
    end
    reads(40);
    chk(rx_empty == 1'b1, "R5 empty after final drain", rx_empty, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule